// File: doc/BRIEF.md
# Fail-Safe Digital Output Bank

This block drives a bank of synchronous digital output pins, 48 by default. In normal running, each pin takes its value from one of two places. One is a bit that the host writes into an output data register. The other is a dedicated alternate signal supplied by another part of the chip. A per-channel source-select bit chooses between them. Whichever source is chosen, the value reaches the pin through a register, so every pin changes exactly one clock after its selected source does.

A single global safe request forces the bank into a protective state. Each channel has a safe-enable bit and a safe-value bit. While the request is high, a channel whose enable is set drives its safe value. A channel whose enable is clear keeps driving its normal run value. Every enable comes out of reset set, so protection is on unless software turns it off. Safe values can only be changed after the host has set a write-key bit. The key comes out of reset clear, so a stray write cannot alter the protective pattern.

The host programs the bank through a one-cycle write strobe. Each write carries a group number and a register code. It updates the 24 channels of that group together and leaves the other group untouched.

Top module: `failsafe_out_bank`

## Requirements
- R1: When a channel is not overridden, its source-select bit 0 drives the pin from the channel's output data bit, and bit 1 drives it from the channel's alternate input.
- R2: While safe_req is 1 and a channel's safe-enable bit is 1, that channel's pin drives its safe-value bit.
- R3: While safe_req is 1 and a channel's safe-enable bit is 0, that channel's pin keeps its normal run value (R1 selection).
- R4: Synchronous reset sets every safe-enable bit to 1. Right after reset, a high safe_req drives the safe values (all 0) even if the output data is later written to 1.
- R5: A write with register code 3 (safe value) changes the safe values only while the write key is 1. With the key at 0 it is ignored. Register code 4 loads the key from wr_data bit 0.
- R6: pin_out is registered. A change on alt_in, safe_req or any configuration bit appears on pin_out one clock edge later.
- R7: A write affects only the group named by wr_grp. wr_data bit j maps to channel wr_grp*24+j, and the other group's registers keep their values.
- R8: A write is captured on the rising edge at which wr_en is sampled 1. The register codes are 0 output data, 1 source select, 2 safe enable, 3 safe value and 4 key; codes 5 to 7 have no effect. The resulting pin value appears one edge after the capture.
- R9: Writing the source select leaves the output data register unchanged. Switching a channel back to source 0 restores its previously written data bit on the pin.
- R10: Reset clears the output data, source select, safe values, write key and pin_out to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling and update clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe, one cycle per write |
| wr_grp | input | 1 | Channel group of the write (0: channels 0-23, 1: channels 24-47) |
| wr_reg | input | 3 | Register code of the write (0 data, 1 source, 2 safe enable, 3 safe value, 4 key) |
| wr_data | input | 24 | Write data, one bit per channel of the group; bit 0 for the key |
| alt_in | input | 48 | Alternate source, one per channel |
| safe_req | input | 1 | Global safe-mode request |
| pin_out | output | 48 | Registered pin values |

## Verification
Two functions can meet in one cycle: a host write and a change of safe_req. A write that changes a channel's data, source or safe enable can be captured on the same edge at which the pin register samples a newly raised or dropped safe request. The bench provokes this on purpose, raising safe_req in the very cycle it writes new data into the enabled and disabled halves of a group. It also does so many times at random. Each pin is judged against a cycle-level reference model. At each edge the model first computes the pin from the configuration held before the edge and then applies the write, so a pin must show the old configuration under the new request for one cycle and the new configuration one cycle later.

// File: rtl/fso_pkg.sv
package fso_pkg;

  typedef enum logic [2:0] {
    REG_OUT_DATA = 3'd0,
    REG_SRC_SEL  = 3'd1,
    REG_SAFE_EN  = 3'd2,
    REG_SAFE_VAL = 3'd3,
    REG_WR_KEY   = 3'd4
  } reg_code_e;

endpackage

// File: rtl/fso_key.sv
module fso_key
  import fso_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [2:0] wr_reg,
  input  logic       wr_bit,
  output logic       key_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      key_q <= 1'b0;
    end else if (wr_en && (reg_code_e'(wr_reg) == REG_WR_KEY)) begin
      key_q <= wr_bit;
    end
  end

  AST_KEY_RESET_CLEAR: assert property (@(posedge clk) rst |=> !key_q); // R10

  AST_KEY_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wr_reg == 3'd4) |=> $stable(key_q)); // R5

endmodule

// File: rtl/fso_group_regs.sv
module fso_group_regs
  import fso_pkg::*;
#(
  parameter int GRP_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hit,
  input  logic [2:0]       wr_reg,
  input  logic [GRP_W-1:0] wr_data,
  input  logic             key,
  output logic [GRP_W-1:0] out_q,
  output logic [GRP_W-1:0] src_q,
  output logic [GRP_W-1:0] sen_q,
  output logic [GRP_W-1:0] sval_q
);

  reg_code_e code;
  assign code = reg_code_e'(wr_reg);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q  <= '0;
      src_q  <= '0;
      sen_q  <= '1;
      sval_q <= '0;
    end else if (hit) begin
      case (code)
        REG_OUT_DATA: out_q <= wr_data;
        REG_SRC_SEL:  src_q <= wr_data;
        REG_SAFE_EN:  sen_q <= wr_data;
        REG_SAFE_VAL: if (key) sval_q <= wr_data;
        default: ;
      endcase
    end
  end

  AST_SEN_RESET_SET: assert property (@(posedge clk) rst |=> (&sen_q)); // R4

  AST_SVAL_LOCKED: assert property (@(posedge clk) disable iff (rst)
    !key |=> $stable(sval_q)); // R5

  AST_IDLE_GROUP_STABLE: assert property (@(posedge clk) disable iff (rst)
    !hit |=> $stable({out_q, src_q, sen_q, sval_q})); // R7

  AST_DATA_KEPT: assert property (@(posedge clk) disable iff (rst)
    !(hit && wr_reg == 3'd0) |=> $stable(out_q)); // R9

endmodule

// File: rtl/fso_pin_mux.sv
module fso_pin_mux #(
  parameter int N_CH = 48
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            safe_req,
  input  logic [N_CH-1:0] out_reg,
  input  logic [N_CH-1:0] src_sel,
  input  logic [N_CH-1:0] alt_in,
  input  logic [N_CH-1:0] safe_en,
  input  logic [N_CH-1:0] safe_val,
  output logic [N_CH-1:0] pin_q
);

  logic [N_CH-1:0] pin_d;

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    logic run_v;
    always_comb begin
      run_v    = src_sel[i] ? alt_in[i] : out_reg[i];
      pin_d[i] = (safe_req && safe_en[i]) ? safe_val[i] : run_v;
    end

    AST_SAFE_DRIVE: assert property (@(posedge clk) disable iff (rst)
      (safe_req && safe_en[i]) |=> pin_q[i] == $past(safe_val[i])); // R2

    AST_RUN_ALT: assert property (@(posedge clk) disable iff (rst)
      (!(safe_req && safe_en[i]) && src_sel[i]) |=> pin_q[i] == $past(alt_in[i])); // R1

    AST_RUN_DATA: assert property (@(posedge clk) disable iff (rst)
      (!(safe_req && safe_en[i]) && !src_sel[i]) |=> pin_q[i] == $past(out_reg[i])); // R3
  end

  always_ff @(posedge clk) begin
    if (rst) pin_q <= '0;
    else     pin_q <= pin_d;
  end

  AST_PIN_RESET: assert property (@(posedge clk) rst |=> (pin_q == '0)); // R10

endmodule

// File: rtl/failsafe_out_bank.sv
module failsafe_out_bank #(
  parameter int N_CH  = 48,
  parameter int GRP_W = 24
) (
  input  logic                                           clk,
  input  logic                                           rst,
  input  logic                                           wr_en,
  input  logic [((N_CH/GRP_W) > 1 ? $clog2(N_CH/GRP_W) : 1)-1:0] wr_grp,
  input  logic [2:0]                                     wr_reg,
  input  logic [GRP_W-1:0]                               wr_data,
  input  logic [N_CH-1:0]                                alt_in,
  input  logic                                           safe_req,
  output logic [N_CH-1:0]                                pin_out
);

  localparam int N_GRP  = N_CH / GRP_W;
  localparam int GSEL_W = (N_GRP > 1) ? $clog2(N_GRP) : 1;

  logic            key;
  logic [N_CH-1:0] out_all, src_all, sen_all, sval_all;
  logic [N_GRP-1:0] hit;

  fso_key u_key (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .wr_reg (wr_reg),
    .wr_bit (wr_data[0]),
    .key_q  (key)
  );

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    assign hit[g] = wr_en && (wr_grp == GSEL_W'(g));

    fso_group_regs #(.GRP_W(GRP_W)) u_regs (
      .clk     (clk),
      .rst     (rst),
      .hit     (hit[g]),
      .wr_reg  (wr_reg),
      .wr_data (wr_data),
      .key     (key),
      .out_q   (out_all [g*GRP_W +: GRP_W]),
      .src_q   (src_all [g*GRP_W +: GRP_W]),
      .sen_q   (sen_all [g*GRP_W +: GRP_W]),
      .sval_q  (sval_all[g*GRP_W +: GRP_W])
    );
  end

  fso_pin_mux #(.N_CH(N_CH)) u_mux (
    .clk      (clk),
    .rst      (rst),
    .safe_req (safe_req),
    .out_reg  (out_all),
    .src_sel  (src_all),
    .alt_in   (alt_in),
    .safe_en  (sen_all),
    .safe_val (sval_all),
    .pin_q    (pin_out)
  );

  AST_ONE_GROUP_HIT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit)); // R7

endmodule

// File: tb/failsafe_out_bank_test.sv
`timescale 1ns/1ps
module failsafe_out_bank_test;

  localparam int N  = 48;
  localparam int GW = 24;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [0:0]    wr_grp = '0;
  logic [2:0]    wr_reg = '0;
  logic [GW-1:0] wr_data = '0;
  logic [N-1:0]  alt_in = '0;
  logic          safe_req = 1'b0;
  logic [N-1:0]  pin_out;

  int    n_total = 0;
  int    n_fail  = 0;
  string cur_req = "R10";

  // reference model state
  logic [N-1:0] m_out, m_src, m_en, m_val, m_pin;
  logic         m_key;

  failsafe_out_bank uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_grp(wr_grp), .wr_reg(wr_reg),
    .wr_data(wr_data), .alt_in(alt_in), .safe_req(safe_req), .pin_out(pin_out)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (rst) begin
      m_out = '0; m_src = '0; m_en = '1; m_val = '0; m_pin = '0; m_key = 1'b0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (safe_req && m_en[i]) m_pin[i] = m_val[i];
        else if (m_src[i])       m_pin[i] = alt_in[i];
        else                     m_pin[i] = m_out[i];
      end
      if (wr_en) begin
        if (wr_reg == 3'd4) m_key = wr_data[0];
        for (int j = 0; j < GW; j++) begin
          case (wr_reg)
            3'd0: m_out[wr_grp*GW + j] = wr_data[j];
            3'd1: m_src[wr_grp*GW + j] = wr_data[j];
            3'd2: m_en [wr_grp*GW + j] = wr_data[j];
            3'd3: if (m_key) m_val[wr_grp*GW + j] = wr_data[j];
            default: ;
          endcase
        end
      end
    end
  end

  task automatic check_pins(input logic [N-1:0] exp, input string req);
    n_total++;
    if (pin_out !== exp) begin
      n_fail++;
      $display("FAIL %s: pin_out=%h expected %h", req, pin_out, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) check_pins(m_pin, cur_req);
  end

  task automatic step(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic host_wr(input int grp, input int code, input logic [GW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_grp = 1'(grp); wr_reg = 3'(code); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin : watchdog
    #1500000;
    n_total++; n_fail++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    step(3);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check_pins('0, "R10");

    // R4: safe request right after reset forces zeros despite data ones
    cur_req = "R4";
    safe_req = 1'b1;
    host_wr(0, 0, '1);
    host_wr(1, 0, '1);
    step(2);
    check_pins('0, "R4");
    safe_req = 1'b0;
    step(2);
    check_pins('1, "R4");

    // R8 / R7: per-group data writes
    cur_req = "R8";
    host_wr(0, 0, 24'hA5C3F0);
    step(1);
    cur_req = "R7";
    host_wr(1, 0, 24'h0F1E2D);
    step(1);
    check_pins({24'h0F1E2D, 24'hA5C3F0}, "R7");
    host_wr(0, 5, 24'h123456);  // unused code, no effect
    step(2);
    check_pins({24'h0F1E2D, 24'hA5C3F0}, "R8");

    // R1: alternate source
    cur_req = "R1";
    alt_in = {24'h00FFFF, 24'hFF00FF};
    host_wr(0, 1, 24'hFFF000);
    step(1);
    alt_in = ~alt_in;
    step(2);
    host_wr(1, 1, '1);
    step(2);

    // R9: back to data source restores stored bits
    cur_req = "R9";
    host_wr(0, 1, '0);
    host_wr(1, 1, '0);
    step(2);
    check_pins({24'h0F1E2D, 24'hA5C3F0}, "R9");

    // R5: locked safe value write ignored, then unlocked
    cur_req = "R5";
    host_wr(0, 3, '1);
    safe_req = 1'b1;
    step(2);
    check_pins({24'h0F1E2D, 24'h000000} & {24'h000000, 24'h000000}, "R5");
    safe_req = 1'b0;
    host_wr(0, 4, 24'h1);
    host_wr(0, 3, 24'h3C3C3C);
    host_wr(1, 3, 24'hC3C3C3);
    host_wr(0, 4, 24'h0);
    host_wr(1, 3, 24'h000000);
    safe_req = 1'b1;
    step(2);
    check_pins({24'hC3C3C3, 24'h3C3C3C}, "R5");

    // R3: cleared enable keeps run value under safe request
    cur_req = "R3";
    host_wr(0, 2, 24'h00FFFF);
    host_wr(1, 2, 24'hFF0000);
    step(2);

    // R2 with concurrent write and safe request edge
    cur_req = "R2";
    safe_req = 1'b0;
    step(2);
    @(negedge clk);
    safe_req = 1'b1; wr_en = 1'b1; wr_grp = 1'b0; wr_reg = 3'd0; wr_data = 24'h5A5A5A;
    @(negedge clk);
    wr_en = 1'b0;
    step(3);

    // R6: random traffic, every cycle compared to the model
    cur_req = "R6";
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      alt_in   = {$urandom, $urandom};
      safe_req = $urandom_range(0, 3) == 0;
      wr_en    = $urandom_range(0, 1) == 1;
      wr_grp   = 1'($urandom_range(0, 1));
      wr_reg   = 3'($urandom_range(0, 5));
      wr_data  = 24'($urandom);
    end
    @(negedge clk);
    wr_en = 1'b0;
    step(3);

    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

endmodule